// File: doc/BRIEF.md
# Multidrop Address Wake/Doze Controller

This block sits between the bit-level deserialiser of a UART receiver and its receive FIFO, in a multidrop network where a ninth flag bit marks a character as an address. For every completed frame it decides whether the character goes into the FIFO. It also decides whether the receiver should be on or off afterwards. The decision uses the frame's address flag, a comparison against the programmed station address, and a two-bit automatic-control field. Host commands to enable, disable and reset the receiver are merged with these automatic decisions. The address recogniser keeps listening while the receiver is off.

The deserialiser reports a start-bit strobe and a frame-complete strobe with the character and its address flag. The block answers one cycle later with a FIFO write, the written character and, for a reset command, a FIFO-clear request. The FIFO applies the clear before the write when both fall in the same cycle. Data delivery after any enable begins only with a frame whose start bit was seen while the receiver was already enabled.

Top module: `mdw_wake_doze_ctrl`

## Requirements
- R1: After the synchronous reset, rx_enabled, fifo_push and fifo_clear are all low.
- R2: When the receiver is enabled and a start strobe has been seen while enabled, a frame-complete strobe produces fifo_push high for one cycle on the next cycle, with fifo_data equal to the character.
- R3: After an enable command, a frame whose start strobe came before the receiver was enabled is not written; the next frame that starts while enabled is written.
- R4: A disable command drives rx_enabled low on the next cycle. It drops the character in progress, so a later frame-complete strobe without a new start strobe writes nothing. It does not raise fifo_clear.
- R5: A reset command raises fifo_clear for one cycle on the next cycle, turns the receiver off and drops the character in progress.
- R6: With the mode field at 00, address characters are written like data, and rx_enabled changes only through host commands.
- R7: With mode bit 0 set (wake), a completed address character equal to station_addr turns the receiver on and is written to the FIFO, even when the receiver was off.
- R8: A wake match overrides a disable or reset command in the same cycle: the receiver ends up on and the address is written; with reset, fifo_clear is raised in that same cycle.
- R9: With mode bit 1 set (doze), a completed address character that differs from station_addr, received while enabled, turns the receiver off; it is written only when keep_foreign is high.
- R10: A foreign address arriving while the receiver is off writes nothing and leaves it off; a matching address in doze-only mode (10) does not turn the receiver on.
- R11: With mode 11, both the wake and the doze behaviour apply, and a doze decision takes priority over an enable command in the same cycle.
- R12: A character without the address flag never triggers wake or doze, even when its value equals station_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_start | input | 1 | Start-bit detected strobe |
| rx_done | input | 1 | Frame-complete strobe |
| rx_char | input | DATA_W | Received character |
| rx_is_addr | input | 1 | Address flag of the received character |
| station_addr | input | DATA_W | Programmed station address |
| auto_mode | input | 2 | Bit 0 wake enable, bit 1 doze enable |
| keep_foreign | input | 1 | Write foreign address characters on doze |
| cmd_enable | input | 1 | Host receiver-enable command strobe |
| cmd_disable | input | 1 | Host receiver-disable command strobe |
| cmd_reset | input | 1 | Host receiver-reset command strobe |
| fifo_push | output | 1 | FIFO write strobe |
| fifo_data | output | DATA_W | Character to write |
| fifo_clear | output | 1 | FIFO pointer realign / status clear request |
| rx_enabled | output | 1 | Receiver enabled status |

## Verification
A host command and a completed frame can land in the same cycle. This is where the automatic decisions and the commands collide. A wake match meets a disable or a reset, and a doze decision meets an enable. The bench sweeps every pairing of mode, prior enable state, character kind, keep_foreign and coincident command. In each case it drives the frame-complete strobe and the command on the same edge. It then judges the write, the written value, the clear request and the final enable state against a result derived from the priority rules in R8 and R11.

// File: rtl/mdw_pkg.sv
package mdw_pkg;

    typedef enum logic [1:0] {
        AUTO_OFF  = 2'b00,
        AUTO_WAKE = 2'b01,
        AUTO_DOZE = 2'b10,
        AUTO_BOTH = 2'b11
    } auto_mode_e;

    typedef struct packed {
        logic go;     // enable command
        logic stop;   // disable command
        logic flush;  // reset command
    } host_cmd_t;

    typedef struct packed {
        logic wake_hit;   // own address seen with wake active
        logic doze_hit;   // foreign address seen while receiving with doze active
        logic data_live;  // frame belongs to the data path
    } verdict_t;

    function automatic logic wake_active(auto_mode_e m);
        return (m == AUTO_WAKE) || (m == AUTO_BOTH);
    endfunction

    function automatic logic doze_active(auto_mode_e m);
        return (m == AUTO_DOZE) || (m == AUTO_BOTH);
    endfunction

    function automatic logic kills_frame(host_cmd_t c);
        return c.stop | c.flush;
    endfunction

endpackage

// File: rtl/mdw_classify.sv
module mdw_classify
    import mdw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              rx_done,
    input  logic              rx_is_addr,
    input  logic [DATA_W-1:0] rx_char,
    input  logic [DATA_W-1:0] station_addr,
    input  auto_mode_e        mode,
    input  host_cmd_t         cmd,
    input  logic              en_q,
    input  logic              armed_q,
    output verdict_t          verdict
);
    logic own_addr;
    logic foreign_addr;
    logic live;

    always_comb begin
        own_addr     = rx_done && rx_is_addr && (rx_char == station_addr);
        foreign_addr = rx_done && rx_is_addr && (rx_char != station_addr);
        live         = rx_done && en_q && armed_q && !kills_frame(cmd);

        verdict.wake_hit  = own_addr && wake_active(mode);
        verdict.doze_hit  = live && foreign_addr && doze_active(mode);
        verdict.data_live = live;
    end

endmodule

// File: rtl/mdw_gate_state.sv
module mdw_gate_state
    import mdw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  host_cmd_t cmd,
    input  logic      rx_start,
    input  logic      rx_done,
    input  verdict_t  verdict,
    output logic      en_q,
    output logic      armed_q
);
    logic en_d;
    logic armed_d;

    always_comb begin
        if (verdict.wake_hit)      en_d = 1'b1;
        else if (kills_frame(cmd)) en_d = 1'b0;
        else if (verdict.doze_hit) en_d = 1'b0;
        else if (cmd.go)           en_d = 1'b1;
        else                       en_d = en_q;

        if (kills_frame(cmd))       armed_d = 1'b0;
        else if (rx_start && en_q)  armed_d = 1'b1;
        else if (rx_done)           armed_d = 1'b0;
        else                        armed_d = armed_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            en_q    <= en_d;
            armed_q <= armed_d;
        end
    end

endmodule

// File: rtl/mdw_fifo_port.sv
module mdw_fifo_port
    import mdw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  verdict_t          verdict,
    input  logic              keep_foreign,
    input  logic [DATA_W-1:0] rx_char,
    input  host_cmd_t         cmd,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_data,
    output logic              fifo_clear
);
    logic push_d;

    always_comb begin
        push_d = verdict.wake_hit
               || (verdict.data_live && !verdict.doze_hit)
               || (verdict.doze_hit && keep_foreign);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_push  <= 1'b0;
            fifo_data  <= '0;
            fifo_clear <= 1'b0;
        end else begin
            fifo_push  <= push_d;
            fifo_clear <= cmd.flush;
            if (push_d) fifo_data <= rx_char;
        end
    end

endmodule

// File: rtl/mdw_wake_doze_ctrl.sv
module mdw_wake_doze_ctrl
    import mdw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_start,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_char,
    input  logic              rx_is_addr,
    input  logic [DATA_W-1:0] station_addr,
    input  logic [1:0]        auto_mode,
    input  logic              keep_foreign,
    input  logic              cmd_enable,
    input  logic              cmd_disable,
    input  logic              cmd_reset,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_data,
    output logic              fifo_clear,
    output logic              rx_enabled
);
    host_cmd_t  cmd;
    auto_mode_e mode;
    verdict_t   verdict;
    logic       en_q;
    logic       armed_q;

    always_comb begin
        cmd.go    = cmd_enable;
        cmd.stop  = cmd_disable;
        cmd.flush = cmd_reset;
        mode      = auto_mode_e'(auto_mode);
    end

    mdw_classify #(.DATA_W(DATA_W)) u_classify (
        .rx_done      (rx_done),
        .rx_is_addr   (rx_is_addr),
        .rx_char      (rx_char),
        .station_addr (station_addr),
        .mode         (mode),
        .cmd          (cmd),
        .en_q         (en_q),
        .armed_q      (armed_q),
        .verdict      (verdict)
    );

    mdw_gate_state u_state (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .rx_start (rx_start),
        .rx_done  (rx_done),
        .verdict  (verdict),
        .en_q     (en_q),
        .armed_q  (armed_q)
    );

    mdw_fifo_port #(.DATA_W(DATA_W)) u_port (
        .clk          (clk),
        .rst          (rst),
        .verdict      (verdict),
        .keep_foreign (keep_foreign),
        .rx_char      (rx_char),
        .cmd          (cmd),
        .fifo_push    (fifo_push),
        .fifo_data    (fifo_data),
        .fifo_clear   (fifo_clear)
    );

    assign rx_enabled = en_q;

endmodule

// File: rtl/mdw_wake_doze_chk.sv
module mdw_wake_doze_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_done,
    input logic              rx_is_addr,
    input logic [DATA_W-1:0] rx_char,
    input logic [DATA_W-1:0] station_addr,
    input logic [1:0]        auto_mode,
    input logic              cmd_enable,
    input logic              cmd_disable,
    input logic              cmd_reset,
    input logic              fifo_push,
    input logic              fifo_clear,
    input logic              rx_enabled
);
    // R2
    push_src_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_push && !$past(rst)) |-> $past(rx_done));

    // R5
    clear_src_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_clear && !$past(rst)) |-> $past(cmd_reset));

    // R7
    en_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(rx_enabled)) |->
        ($past(cmd_enable) || $past(rx_done && rx_is_addr && auto_mode[0]
                                    && (rx_char == station_addr))));

    // R9
    en_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(rx_enabled)) |->
        ($past(cmd_disable) || $past(cmd_reset)
         || $past(rx_done && rx_is_addr && auto_mode[1])));

    // R6
    manual_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(auto_mode == 2'b00) && (rx_enabled != $past(rx_enabled)))
        |-> $past(cmd_enable || cmd_disable || cmd_reset));

endmodule

bind mdw_wake_doze_ctrl mdw_wake_doze_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_done      (rx_done),
    .rx_is_addr   (rx_is_addr),
    .rx_char      (rx_char),
    .station_addr (station_addr),
    .auto_mode    (auto_mode),
    .cmd_enable   (cmd_enable),
    .cmd_disable  (cmd_disable),
    .cmd_reset    (cmd_reset),
    .fifo_push    (fifo_push),
    .fifo_clear   (fifo_clear),
    .rx_enabled   (rx_enabled)
);

// File: tb/mdw_wake_doze_ctrl_bench.sv
module mdw_wake_doze_ctrl_bench;
    localparam int DW = 8;
    localparam logic [DW-1:0] STN = 8'h5A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_start = 0, rx_done = 0, rx_is_addr = 0, keep_foreign = 0;
    logic cmd_enable = 0, cmd_disable = 0, cmd_reset = 0;
    logic [DW-1:0] rx_char = '0;
    logic [DW-1:0] station_addr = STN;
    logic [1:0] auto_mode = 2'b00;
    logic fifo_push, fifo_clear, rx_enabled;
    logic [DW-1:0] fifo_data;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mdw_wake_doze_ctrl #(.DATA_W(DW)) u_mdw_wake_doze_ctrl (
        .clk(clk), .rst(rst), .rx_start(rx_start), .rx_done(rx_done),
        .rx_char(rx_char), .rx_is_addr(rx_is_addr), .station_addr(station_addr),
        .auto_mode(auto_mode), .keep_foreign(keep_foreign),
        .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_reset(cmd_reset),
        .fifo_push(fifo_push), .fifo_data(fifo_data), .fifo_clear(fifo_clear),
        .rx_enabled(rx_enabled)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        rx_start = 0; rx_done = 0; rx_is_addr = 0;
        cmd_enable = 0; cmd_disable = 0; cmd_reset = 0;
    endtask

    // one cycle with the present inputs, then sample after the edge
    task automatic cycle();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); idle(); rst = 1;
        @(negedge clk); rst = 0;
    endtask

    task automatic pulse_enable();
        @(negedge clk); idle(); cmd_enable = 1;
        @(negedge clk); idle();
    endtask

    task automatic pulse_start();
        @(negedge clk); idle(); rx_start = 1;
        @(negedge clk); idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        @(negedge clk); @(negedge clk);
        rst = 0;
        check("R1 rx_enabled", rx_enabled, 0);
        check("R1 fifo_push", fifo_push, 0);
        check("R1 fifo_clear", fifo_clear, 0);

        // R3: start seen before enable is not enough
        do_reset();
        pulse_start();
        pulse_enable();
        @(negedge clk); idle(); rx_done = 1; rx_char = 8'h11;
        @(negedge clk);
        check("R3 stale frame push", fifo_push, 0);
        idle();
        pulse_start();
        @(negedge clk); idle(); rx_done = 1; rx_char = 8'h22;
        @(negedge clk);
        check("R3 next frame push", fifo_push, 1);
        check("R2 data value", fifo_data, 8'h22);
        idle();

        // R4: disable drops partial character, no clear
        pulse_start();
        @(negedge clk); idle(); cmd_disable = 1;
        @(negedge clk);
        check("R4 rx_enabled low", rx_enabled, 0);
        check("R4 no clear", fifo_clear, 0);
        idle();
        pulse_enable();
        @(negedge clk); idle(); rx_done = 1; rx_char = 8'h44;
        @(negedge clk);
        check("R4 partial dropped", fifo_push, 0);
        idle();

        // R5: reset command drops partial character
        pulse_start();
        @(negedge clk); idle(); cmd_reset = 1;
        @(negedge clk);
        check("R5 clear pulse", fifo_clear, 1);
        idle();
        @(negedge clk);
        check("R5 clear one cycle", fifo_clear, 0);
        pulse_enable();
        @(negedge clk); idle(); rx_done = 1; rx_char = 8'h55;
        @(negedge clk);
        check("R5 partial dropped", fifo_push, 0);
        idle();

        // Sweep: mode x prior enable x kind x keep x coincident command
        for (int m = 0; m < 4; m++)
        for (int pre = 0; pre < 2; pre++)
        for (int k = 0; k < 4; k++)
        for (int kp = 0; kp < 2; kp++)
        for (int c = 0; c < 4; c++) begin
            logic is_a, match, kill, wake, live, doze, e_push, e_en, e_clr;
            logic [DW-1:0] ch;
            do_reset();
            auto_mode = m[1:0]; keep_foreign = kp[0];
            if (pre == 1) begin
                pulse_enable();
                pulse_start();
            end
            ch    = (k == 0) ? 8'h33 : (k == 2) ? 8'hA5 : STN;
            is_a  = (k == 1) || (k == 2);
            match = (k == 1);
            kill  = (c >= 2);
            wake  = match && m[0];
            live  = (pre == 1) && !kill;
            doze  = live && (k == 2) && m[1];
            e_push = wake || (live && !doze) || (doze && kp[0]);
            e_en   = wake ? 1'b1 : kill ? 1'b0 : doze ? 1'b0 : (c == 1) ? 1'b1 : pre[0];
            e_clr  = (c == 3);
            @(negedge clk); idle();
            rx_done = 1; rx_char = ch; rx_is_addr = is_a;
            cmd_enable = (c == 1); cmd_disable = (c == 2); cmd_reset = (c == 3);
            @(negedge clk);
            // R6 R7 R8 R9 R10 R11 R12 judged together per scenario
            check(m == 0 ? "R6 push" : wake ? "R7/R8 push" : doze ? "R9 push" :
                  (k == 3) ? "R12 push" : (pre == 0) ? "R10 push" : "R2 push",
                  fifo_push, e_push);
            if (e_push) check("R2 fifo_data", fifo_data, ch);
            check(wake && kill ? "R8 enable" : (m == 3) ? "R11 enable" :
                  doze ? "R9 enable" : (m == 2 && pre == 0) ? "R10 enable" : "R6 enable",
                  rx_enabled, e_en);
            check(wake && c == 3 ? "R8 clear" : "R5 clear", fifo_clear, e_clr);
            idle();
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule